// File: doc/BRIEF.md
# Exception Control Coprocessor

This unit is the system-control coprocessor beside a small 32-bit RISC pipeline. It holds four architected registers: a cause record (number 13), the saved return address (number 14), a mode/mask word (number 12) and the faulting address of the last address error (number 8). When the pipeline reports a synchronous exception, or an enabled interrupt line is high while the core is in user mode, the unit records why and where, moves to kernel mode and, in that same cycle, redirects fetch to the fixed handler entry 0x8000_0180.

Kernel code reads and writes the registers through a move-from port (combinational read by register number) and a move-to port (write on the clock edge). The return operation sends fetch back to the saved address and leaves that address untouched. Software advances it by four when the faulting instruction is to be skipped.

The mode is a two-state machine. MODE_USER goes to MODE_KERNEL on a taken exception (EV_EXC), a taken interrupt (EV_IRQ), or a move-to of Status with bit 1 set. MODE_KERNEL goes to MODE_USER on a return (EV_RET) or a move-to of Status with bit 1 clear. In MODE_KERNEL a new exception keeps the state in MODE_KERNEL and captures again. Event priority is EV_EXC, then EV_IRQ, then EV_RET. EV_NONE leaves everything unchanged.

Top module: `sysctl_cop`

## Requirements
- R1: In the cycle `exc_req` is high, `redirect_valid` is 1 and `redirect_pc` is 0x8000_0180 (combinational).
- R2: Register 13 reads as follows: bit 31 holds the captured delay-slot flag; bits 29:28 hold the captured coprocessor number; bits 6:2 hold the exception code. All other bits except 15:8 read 0. The codes are 0 interrupt, 4 address error on fetch/load, 5 address error on store, 8 syscall, 9 breakpoint, 12 overflow, 13 trap.
- R3: Bits 15:8 of register 13 always equal the present level of `irq_lines`. Move-to writes to those bits have no effect.
- R4: On a taken exception or interrupt, register 14 becomes `cur_pc` when `cur_bd` is 0 and `cur_pc - 4` when `cur_bd` is 1.
- R5: A return (`eret`) with no exception or taken interrupt in that cycle drives `redirect_valid`=1 and `redirect_pc` equal to register 14. Register 14 keeps its value and Status bit 1 clears on the next edge.
- R6: Register 12 holds IE in bit 0, EXL in bit 1 and the interrupt mask in bits 15:8; all other bits read 0. A taken exception or interrupt sets EXL.
- R7: An interrupt is taken (code 0, redirect to the handler) exactly when `exc_req` is 0, IE is 1, EXL is 0 and `irq_lines` AND mask is nonzero.
- R8: Register 8 is loaded with `fault_addr` on exceptions with code 4 or 5 only. Other codes leave it unchanged.
- R9: The move-to port writes registers 8, 12, 13 and 14 on the clock edge. The move-from port returns them combinationally. Any other register number reads 0.
- R10: When a capture and a move-to hit the same register in one cycle, the capture wins and the write is dropped. A move-to to a register the capture does not touch still takes effect.
- R11: When `exc_req` and `eret` are high together, the exception is taken: fetch goes to the handler, EXL ends set, and register 14 is captured.
- R12: After reset all four registers read 0 (apart from the live bits 15:8 of register 13) and `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception reported this cycle |
| exc_code | input | 5 | Exception code of the request |
| exc_ce | input | 2 | Coprocessor number for the cause record |
| cur_pc | input | 32 | Address of the instruction being retired or faulting |
| cur_bd | input | 1 | That instruction sits in a branch delay slot |
| fault_addr | input | 32 | Faulting fetch or data address |
| irq_lines | input | 8 | Level interrupt sources |
| rd_addr | input | 5 | Move-from register number |
| rd_data | output | 32 | Move-from data |
| wr_en | input | 1 | Move-to strobe |
| wr_addr | input | 5 | Move-to register number |
| wr_data | input | 32 | Move-to data |
| eret | input | 1 | Exception-return request |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Restart address |

## Verification
The hardware capture and a software move-to can target the same register in one cycle. The bench provokes this by raising `exc_req` together with a move-to to register 14, 13, 12 or 8, and then reads each register back on the next cycle. The captured values must win, and a write to the address register must survive when the exception code is not an address error. The exception-versus-return collision is provoked the same way: `exc_req` and `eret` go high together. The bench then judges the redirect target in that cycle, and the EXL bit and saved address after it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int XLEN = 32;
    localparam int RNUM_W = 5;
    localparam int CODE_W = 5;

    localparam logic [RNUM_W-1:0] REG_BADVA  = 5'd8;
    localparam logic [RNUM_W-1:0] REG_STATUS = 5'd12;
    localparam logic [RNUM_W-1:0] REG_CAUSE  = 5'd13;
    localparam logic [RNUM_W-1:0] REG_EPC    = 5'd14;

    localparam logic [CODE_W-1:0] CODE_INT    = 5'd0;
    localparam logic [CODE_W-1:0] CODE_ADEL   = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ADES   = 5'd5;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2,
        EV_RET  = 2'd3
    } ev_t;

    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } mode_t;
endpackage

// File: rtl/sysctl_arb.sv
module sysctl_arb
    import sysctl_pkg::*;
(
    input  logic exc_req,
    input  logic irq_hit,
    input  logic eret,
    output ev_t  ev
);
    always_comb begin
        if (exc_req)      ev = EV_EXC;
        else if (irq_hit) ev = EV_IRQ;
        else if (eret)    ev = EV_RET;
        else              ev = EV_NONE;
    end
endmodule

// File: rtl/sysctl_mode.sv
module sysctl_mode
    import sysctl_pkg::*;
#(
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ev_t             ev,
    input  logic            wr_status,
    input  logic            wr_exl,
    input  logic [XLEN-1:0] epc,
    output logic            exl,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    mode_t state, state_nx;
    logic  take;

    assign take = (ev == EV_EXC) || (ev == EV_IRQ);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_USER;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_USER: begin
                if (take)                     state_nx = MODE_KERNEL;
                else if (wr_status && wr_exl) state_nx = MODE_KERNEL;
            end
            MODE_KERNEL: begin
                if (take)                      state_nx = MODE_KERNEL;
                else if (ev == EV_RET)         state_nx = MODE_USER;
                else if (wr_status && !wr_exl) state_nx = MODE_USER;
            end
        endcase
    end

    always_comb begin
        exl            = (state == MODE_KERNEL);
        redirect_valid = (ev != EV_NONE);
        redirect_pc    = take ? VECTOR : epc;
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_t               ev,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [1:0]        exc_ce,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              cur_bd,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [IRQ_W-1:0]  irq_lines,
    input  logic              exl,
    input  logic              wr_en,
    input  logic [RNUM_W-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [RNUM_W-1:0] rd_addr,
    output logic [XLEN-1:0]   rd_data,
    output logic [XLEN-1:0]   epc_o,
    output logic              ie_o,
    output logic [IRQ_W-1:0]  im_o
);
    localparam int IP_LO = 8;

    logic              take, is_irq, addr_err;
    logic [CODE_W-1:0] code_eff;
    logic [1:0]        ce_eff;
    logic [XLEN-1:0]   epc_q, badva_q;
    logic [CODE_W-1:0] code_q;
    logic [1:0]        ce_q;
    logic              bd_q, ie_q;
    logic [IRQ_W-1:0]  im_q;
    logic [XLEN-1:0]   cause_v, status_v;

    assign take     = (ev == EV_EXC) || (ev == EV_IRQ);
    assign is_irq   = (ev == EV_IRQ);
    assign code_eff = is_irq ? CODE_INT : exc_code;
    assign ce_eff   = is_irq ? 2'd0 : exc_ce;
    assign addr_err = (ev == EV_EXC) && ((code_eff == CODE_ADEL) || (code_eff == CODE_ADES));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            badva_q <= '0;
            code_q  <= '0;
            ce_q    <= '0;
            bd_q    <= 1'b0;
            ie_q    <= 1'b0;
            im_q    <= '0;
        end else begin
            if (take)
                epc_q <= cur_bd ? (cur_pc - 32'd4) : cur_pc;
            else if (wr_en && wr_addr == REG_EPC)
                epc_q <= wr_data;

            if (take) begin
                code_q <= code_eff;
                ce_q   <= ce_eff;
                bd_q   <= cur_bd;
            end else if (wr_en && wr_addr == REG_CAUSE) begin
                code_q <= wr_data[6:2];
                ce_q   <= wr_data[29:28];
                bd_q   <= wr_data[31];
            end

            if (addr_err)
                badva_q <= fault_addr;
            else if (wr_en && wr_addr == REG_BADVA)
                badva_q <= wr_data;

            if (!take && wr_en && wr_addr == REG_STATUS) begin
                ie_q <= wr_data[0];
                im_q <= wr_data[IP_LO +: IRQ_W];
            end
        end
    end

    always_comb begin
        cause_v                 = '0;
        cause_v[31]             = bd_q;
        cause_v[29:28]          = ce_q;
        cause_v[IP_LO +: IRQ_W] = irq_lines;
        cause_v[6:2]            = code_q;
        status_v                = '0;
        status_v[0]             = ie_q;
        status_v[1]             = exl;
        status_v[IP_LO +: IRQ_W] = im_q;
    end

    always_comb begin
        case (rd_addr)
            REG_BADVA:  rd_data = badva_q;
            REG_STATUS: rd_data = status_v;
            REG_CAUSE:  rd_data = cause_v;
            REG_EPC:    rd_data = epc_q;
            default:    rd_data = '0;
        endcase
    end

    assign epc_o = epc_q;
    assign ie_o  = ie_q;
    assign im_o  = im_q;
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int              IRQ_W  = 8,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [4:0]        exc_code,
    input  logic [1:0]        exc_ce,
    input  logic [31:0]       cur_pc,
    input  logic              cur_bd,
    input  logic [31:0]       fault_addr,
    input  logic [IRQ_W-1:0]  irq_lines,
    input  logic [4:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              eret,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc
);
    ev_t              ev;
    logic             exl, ie, irq_hit, wr_status;
    logic [IRQ_W-1:0] im, irq_m;
    logic [XLEN-1:0]  epc;

    for (genvar g = 0; g < IRQ_W; g++) begin : g_mask
        assign irq_m[g] = irq_lines[g] & im[g];
    end

    assign irq_hit   = ie && !exl && (|irq_m);
    assign wr_status = wr_en && (wr_addr == REG_STATUS);

    sysctl_arb u_arb (
        .exc_req (exc_req),
        .irq_hit (irq_hit),
        .eret    (eret),
        .ev      (ev)
    );

    sysctl_mode #(.VECTOR(VECTOR)) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev             (ev),
        .wr_status      (wr_status),
        .wr_exl         (wr_data[1]),
        .epc            (epc),
        .exl            (exl),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    sysctl_regs #(.IRQ_W(IRQ_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .exc_code   (exc_code),
        .exc_ce     (exc_ce),
        .cur_pc     (cur_pc),
        .cur_bd     (cur_bd),
        .fault_addr (fault_addr),
        .irq_lines  (irq_lines),
        .exl        (exl),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .epc_o      (epc),
        .ie_o       (ie),
        .im_o       (im)
    );
endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk
    import sysctl_pkg::*;
#(
    parameter int              IRQ_W  = 8,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_req,
    input logic             eret,
    input logic [31:0]      cur_pc,
    input logic             cur_bd,
    input logic [IRQ_W-1:0] irq_lines,
    input logic [4:0]       rd_addr,
    input logic [31:0]      rd_data,
    input logic             wr_en,
    input logic [4:0]       wr_addr,
    input logic             redirect_valid,
    input logic [31:0]      redirect_pc,
    input logic [31:0]      epc,
    input logic             exl,
    input ev_t              ev
);
    a_r1_vector: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (redirect_valid && redirect_pc == VECTOR));

    a_r4_epc_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !cur_bd) |=> (epc == $past(cur_pc)));

    a_r4_epc_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && cur_bd) |=> (epc == $past(cur_pc) - 32'd4));

    a_r6_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> exl);

    a_r5_ret_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RET) |=> !exl);

    a_r5_epc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RET && !(wr_en && wr_addr == REG_EPC)) |=> $stable(epc));

    a_r3_ip_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_CAUSE) |-> (rd_data[15:8] == irq_lines));

    a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_CAUSE) |-> (rd_data[30] == 1'b0 && rd_data[27:16] == '0
                                     && rd_data[7] == 1'b0 && rd_data[1:0] == '0));

    a_r7_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (exl && !exc_req && !eret) |-> !redirect_valid);
endmodule

bind sysctl_cop sysctl_cop_chk #(.IRQ_W(IRQ_W), .VECTOR(VECTOR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req        (exc_req),
    .eret           (eret),
    .cur_pc         (cur_pc),
    .cur_bd         (cur_bd),
    .irq_lines      (irq_lines),
    .rd_addr        (rd_addr),
    .rd_data        (rd_data),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .epc            (epc),
    .exl            (exl),
    .ev             (ev)
);

// File: tb/sysctl_cop_tb.sv
module sysctl_cop_tb;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [1:0]  exc_ce = '0;
    logic [31:0] cur_pc = '0;
    logic        cur_bd = 1'b0;
    logic [31:0] fault_addr = '0;
    logic [7:0]  irq_lines = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        eret = 1'b0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_cop u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_ce(exc_ce), .cur_pc(cur_pc), .cur_bd(cur_bd), .fault_addr(fault_addr),
        .irq_lines(irq_lines), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .eret(eret),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic mtc(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cause_of(input logic bd, input logic [1:0] ce,
                                             input logic [7:0] ip, input logic [4:0] code);
        return {bd, 1'b0, ce, 12'h000, ip, 1'b0, code, 2'b00};
    endfunction

    task automatic do_ret(input logic [31:0] epc_exp);
        eret = 1'b1;
        #0.5;
        chk("R5 ret valid", {31'b0, redirect_valid}, 32'd1);
        chk("R5 ret target", redirect_pc, epc_exp);
        tick();
        eret = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, bva_exp, epc_exp;
        logic [4:0] codes [6];
        codes = '{5'd4, 5'd5, 5'd8, 5'd9, 5'd12, 5'd13};

        repeat (3) tick();
        rst_n = 1'b1;
        #0.5;
        // R12 reset state
        chk("R12 redirect", {31'b0, redirect_valid}, 32'd0);
        rd(5'd8, d);  chk("R12 badva", d, 32'd0);
        rd(5'd12, d); chk("R12 status", d, 32'd0);
        rd(5'd13, d); chk("R12 cause", d, 32'd0);
        rd(5'd14, d); chk("R12 epc", d, 32'd0);

        // R1 R2 R4 R6 R8 R5 sweep over codes, delay flag and coprocessor number
        bva_exp = '0;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 2; b++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [31:0] pc;
                    pc = 32'h0040_0000 + 32'((i * 8 + b * 4 + c) * 16);
                    exc_req = 1'b1; exc_code = codes[i]; exc_ce = 2'(c);
                    cur_pc = pc; cur_bd = 1'(b);
                    fault_addr = 32'h1000_0003 + 32'(i * 64 + b * 8 + c);
                    #0.5;
                    chk("R1 valid", {31'b0, redirect_valid}, 32'd1);
                    chk("R1 vector", redirect_pc, VEC);
                    if (codes[i] == 5'd4 || codes[i] == 5'd5) bva_exp = fault_addr;
                    epc_exp = b ? pc - 32'd4 : pc;
                    tick();
                    exc_req = 1'b0;
                    rd(5'd13, d); chk("R2 cause", d, cause_of(1'(b), 2'(c), 8'h00, codes[i]));
                    rd(5'd14, d); chk("R4 epc", d, epc_exp);
                    rd(5'd8, d);  chk("R8 badva", d, bva_exp);
                    rd(5'd12, d); chk("R6 exl set", d, 32'h0000_0002);
                    do_ret(epc_exp);
                    rd(5'd14, d); chk("R5 epc kept", d, epc_exp);
                    rd(5'd12, d); chk("R5 exl clear", d, 32'h0000_0000);
                end
            end
        end

        // R9 move-to / move-from
        mtc(5'd14, 32'hDEAD_BEEC); rd(5'd14, d); chk("R9 epc rw", d, 32'hDEAD_BEEC);
        mtc(5'd8, 32'h1234_5678);  rd(5'd8, d);  chk("R9 badva rw", d, 32'h1234_5678);
        mtc(5'd12, 32'hFFFF_FFFF); rd(5'd12, d); chk("R9 status rw", d, 32'h0000_FF03);
        mtc(5'd12, 32'h0000_0000); rd(5'd12, d); chk("R9 status clr", d, 32'h0000_0000);
        mtc(5'd5, 32'hFFFF_FFFF);  rd(5'd5, d);  chk("R9 unimpl", d, 32'h0000_0000);
        rd(5'd0, d); chk("R9 reg0", d, 32'h0000_0000);
        // R3 writes to pending bits ignored; other cause fields writable
        mtc(5'd13, 32'hFFFF_FFFF); rd(5'd13, d); chk("R3 ip write ignored", d, 32'hB000_007C);
        mtc(5'd13, 32'h0000_0000);

        // R3 live mirror of every irq level (interrupts disabled)
        for (int q = 0; q < 256; q++) begin
            irq_lines = 8'(q);
            rd(5'd13, d);
            chk("R3 ip live", d, {16'h0, 8'(q), 8'h00});
            chk("R7 no irq when IE=0", {31'b0, redirect_valid}, 32'd0);
        end
        irq_lines = '0;

        // R7 interrupt acceptance sweep
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 4; m++) begin
                for (int q = 0; q < 16; q++) begin
                    logic [7:0] im, irq;
                    logic exp_take;
                    im  = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : (m == 2) ? 8'h0F : 8'hA5;
                    irq = 8'(q * 17);
                    exp_take = (ie == 1) && ((irq & im) != 8'h00);
                    mtc(5'd12, {16'h0, im, 7'b0, 1'(ie)});
                    irq_lines = irq; cur_pc = 32'h0050_0000 + 32'(q * 4); cur_bd = 1'b0;
                    #0.5;
                    chk("R7 take", {31'b0, redirect_valid}, {31'b0, exp_take});
                    if (exp_take) chk("R7 vector", redirect_pc, VEC);
                    tick();
                    irq_lines = '0;
                    if (exp_take) begin
                        rd(5'd13, d); chk("R7 code0", d, 32'h0000_0000);
                        rd(5'd14, d); chk("R7 epc", d, cur_pc);
                        rd(5'd12, d); chk("R7 exl", d, {16'h0, im, 6'b0, 2'b11});
                        do_ret(cur_pc);
                    end
                end
            end
        end
        // R7 blocked while EXL set
        mtc(5'd12, 32'h0000_FF03);
        irq_lines = 8'hFF;
        #0.5;
        chk("R7 blocked by EXL", {31'b0, redirect_valid}, 32'd0);
        tick();
        irq_lines = '0;
        mtc(5'd12, 32'h0000_0000);

        // R10 capture versus move-to, same register
        exc_req = 1'b1; exc_code = 5'd8; exc_ce = 2'd0; cur_pc = 32'h0060_0000; cur_bd = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd14; wr_data = 32'h1111_1110;
        tick();
        exc_req = 1'b0; wr_en = 1'b0;
        rd(5'd14, d); chk("R10 epc capture wins", d, 32'h0060_0000);
        do_ret(32'h0060_0000);

        exc_req = 1'b1; exc_code = 5'd12; exc_ce = 2'd1; cur_bd = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd13; wr_data = 32'h3000_0034;
        tick();
        exc_req = 1'b0; wr_en = 1'b0; cur_bd = 1'b0;
        rd(5'd13, d); chk("R10 cause capture wins", d, cause_of(1'b1, 2'd1, 8'h00, 5'd12));
        do_ret(32'h005F_FFFC);

        exc_req = 1'b1; exc_code = 5'd9; fault_addr = 32'h7777_0000;
        wr_en = 1'b1; wr_addr = 5'd8; wr_data = 32'hCAFE_0001;
        tick();
        exc_req = 1'b0; wr_en = 1'b0;
        rd(5'd8, d); chk("R10 badva write kept", d, 32'hCAFE_0001);
        do_ret(32'h0060_0000);

        exc_req = 1'b1; exc_code = 5'd5; fault_addr = 32'h7777_0004;
        wr_en = 1'b1; wr_addr = 5'd8; wr_data = 32'hCAFE_0002;
        tick();
        exc_req = 1'b0; wr_en = 1'b0;
        rd(5'd8, d); chk("R10 badva capture wins", d, 32'h7777_0004);
        do_ret(32'h0060_0000);

        exc_req = 1'b1; exc_code = 5'd13;
        wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'h0000_FF01;
        tick();
        exc_req = 1'b0; wr_en = 1'b0;
        rd(5'd12, d); chk("R10 status write dropped", d, 32'h0000_0002);
        do_ret(32'h0060_0000);

        // R11 exception beats return
        mtc(5'd14, 32'h0000_4444);
        exc_req = 1'b1; eret = 1'b1; exc_code = 5'd8; cur_pc = 32'h0070_0010; cur_bd = 1'b0;
        #0.5;
        chk("R11 vector", redirect_pc, VEC);
        tick();
        exc_req = 1'b0; eret = 1'b0;
        rd(5'd12, d); chk("R11 exl", d, 32'h0000_0002);
        rd(5'd14, d); chk("R11 epc", d, 32'h0070_0010);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule